// File: doc/BRIEF.md
# Compare and Trap Condition Unit

This unit compares a 32-bit register operand A against a second operand B and produces one of two results. B is either a second register value or a 16-bit immediate. The immediate is sign-extended for a signed operation and zero-extended for an unsigned one. A compare operation writes a 4-bit result (less-than, greater-than, equal, summary-overflow) into one of eight fields of a 32-bit condition register that the unit holds. The rest of that register keeps its contents.

A trap operation leaves the condition register alone. It tests five relations between A and B, each enabled by its own option bit, and raises a trap request if any enabled relation holds. The signed relations are computed by inverting the sign bit of both operands and then comparing them as unsigned numbers. The caller issues one operation per `start` pulse. The results appear one cycle later, together with a single-cycle `done` pulse.

Top module: `cmp_trap_unit`

## Requirements
- R1: After reset `cr_out` is 0 and both `done` and `trap_req` are 0.
- R2: `done` is high exactly in the cycle after a cycle in which `start` was high, and low in every other cycle.
- R3: When `use_imm`=1, B is `imm` sign-extended to 32 bits if `signed_sel`=1 and zero-extended if `signed_sel`=0. When `use_imm`=0, B is `opnd_b`.
- R4: With `signed_sel`=1 the compare treats A and B as two's-complement values. With `signed_sel`=0 it treats them as unsigned values.
- R5: A compare result nibble holds LT in bit 3, GT in bit 2, EQ in bit 1 and `sum_ovf` in bit 0. Exactly one of LT, GT and EQ is set.
- R6: Field f (`fld_sel`=f) occupies `cr_out[31-4f : 28-4f]`, so field 0 is the most significant nibble.
- R7: A compare replaces only the selected nibble. The other 28 bits of `cr_out` keep their values.
- R8: For a trap, `trap_opts` bit 4 enables signed A<B, bit 3 enables signed A>B, bit 2 enables A==B, bit 1 enables unsigned A<B and bit 0 enables unsigned A>B. `trap_req` is 1 in the `done` cycle if any enabled relation holds, and 0 otherwise.
- R9: `op_sel`=0 selects compare and `op_sel`=1 selects trap. A compare never raises `trap_req`, and a trap leaves `cr_out` unchanged.
- R10: `trap_req` is high only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue one operation this cycle |
| op_sel | input | 1 | 0 = compare into the condition register, 1 = trap test |
| signed_sel | input | 1 | Signed compare and immediate sign extension |
| use_imm | input | 1 | Take B from `imm` instead of `opnd_b` |
| imm | input | 16 | Immediate operand |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| fld_sel | input | 3 | Condition register field to update |
| trap_opts | input | 5 | Trap relation enables |
| sum_ovf | input | 1 | Summary-overflow bit copied into the field |
| cr_out | output | 32 | Condition register |
| trap_req | output | 1 | Trap request, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Operand pairs whose signed and unsigned orderings disagree, such as a negative value against a small positive one, are compared both ways. This shows whether the sign-bit handling matches `signed_sel`. The same negative immediate is used with both extension modes, which distinguishes sign extension from zero extension. Every field index is written in turn over a background pattern, which exposes a misplaced nibble or bits that were disturbed outside it. For traps, each option bit is enabled on its own against pairs where only some relations hold, so each mask bit is tied to its relation. A compare with every option bit set confirms that the two result paths stay separate.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int FLD_W  = 4;
  localparam int NIB_LT = 3;
  localparam int NIB_GT = 2;
  localparam int NIB_EQ = 1;
  localparam int NIB_SO = 0;

  typedef enum logic {
    OP_CMP  = 1'b0,
    OP_TRAP = 1'b1
  } op_e;

  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } rel_t;
endpackage

// File: rtl/cmpt_operand_sel.sv
module cmpt_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              use_imm,
  input  logic              sign_ext,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] opnd
);
  localparam int PAD_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] widen(input logic [IMM_W-1:0] v, input logic sx);
    logic fill;
    fill = sx & v[IMM_W-1];
    return {{PAD_W{fill}}, v};
  endfunction

  assign opnd = use_imm ? widen(imm, sign_ext) : reg_b;
endmodule

// File: rtl/cmpt_rel_eval.sv
module cmpt_rel_eval
  import cmpt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output rel_t              rel
);
  function automatic logic [DATA_W-1:0] bias(input logic [DATA_W-1:0] v);
    return {~v[DATA_W-1], v[DATA_W-2:0]};
  endfunction

  logic [DATA_W-1:0] a_b, b_b;
  assign a_b = bias(a);
  assign b_b = bias(b);

  always_comb begin
    rel.slt = a_b < b_b;
    rel.sgt = a_b > b_b;
    rel.eq  = a == b;
    rel.ult = a < b;
    rel.ugt = a > b;
  end
endmodule

// File: rtl/cmpt_cr_merge.sv
module cmpt_cr_merge
  import cmpt_pkg::*;
#(
  parameter int NFIELD = 8,
  localparam int CR_W  = NFIELD * FLD_W,
  localparam int SEL_W = $clog2(NFIELD)
) (
  input  logic [CR_W-1:0]  cr_cur,
  input  logic [SEL_W-1:0] fld,
  input  logic [FLD_W-1:0] nib,
  output logic [CR_W-1:0]  cr_next,
  output logic [CR_W-1:0]  keep_mask
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam int LO = (NFIELD - 1 - g) * FLD_W;
    logic hit;
    assign hit = (fld == SEL_W'(g));
    assign cr_next[LO +: FLD_W]   = hit ? nib : cr_cur[LO +: FLD_W];
    assign keep_mask[LO +: FLD_W] = {FLD_W{~hit}};
  end
endmodule

// File: rtl/cmpt_trap_eval.sv
module cmpt_trap_eval
  import cmpt_pkg::*;
(
  input  logic [4:0] opts,
  input  rel_t       rel,
  output logic       hit
);
  function automatic logic any_enabled(input logic [4:0] m, input rel_t r);
    return |(m & {r.slt, r.sgt, r.eq, r.ult, r.ugt});
  endfunction

  assign hit = any_enabled(opts, rel);
endmodule

// File: rtl/cmp_trap_unit.sv
module cmp_trap_unit
  import cmpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int NFIELD = 8,
  localparam int CR_W  = NFIELD * FLD_W,
  localparam int SEL_W = $clog2(NFIELD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_sel,
  input  logic              signed_sel,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SEL_W-1:0]  fld_sel,
  input  logic [4:0]        trap_opts,
  input  logic              sum_ovf,
  output logic [CR_W-1:0]   cr_out,
  output logic              trap_req,
  output logic              done
);
  logic [DATA_W-1:0] b_eff;
  rel_t              rel;
  logic [FLD_W-1:0]  nib;
  logic [CR_W-1:0]   cr_next, keep_mask;
  logic              trap_hit;
  logic              is_trap, cmp_fire, trap_fire;

  cmpt_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .use_imm (use_imm),
    .sign_ext(signed_sel),
    .imm     (imm),
    .reg_b   (opnd_b),
    .opnd    (b_eff)
  );

  cmpt_rel_eval #(.DATA_W(DATA_W)) u_rel (
    .a  (opnd_a),
    .b  (b_eff),
    .rel(rel)
  );

  always_comb begin
    nib         = '0;
    nib[NIB_LT] = signed_sel ? rel.slt : rel.ult;
    nib[NIB_GT] = signed_sel ? rel.sgt : rel.ugt;
    nib[NIB_EQ] = rel.eq;
    nib[NIB_SO] = sum_ovf;
  end

  cmpt_cr_merge #(.NFIELD(NFIELD)) u_merge (
    .cr_cur   (cr_out),
    .fld      (fld_sel),
    .nib      (nib),
    .cr_next  (cr_next),
    .keep_mask(keep_mask)
  );

  cmpt_trap_eval u_trap (
    .opts(trap_opts),
    .rel (rel),
    .hit (trap_hit)
  );

  assign is_trap   = (op_sel == OP_TRAP);
  assign cmp_fire  = start & ~is_trap;
  assign trap_fire = start & is_trap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_out   <= '0;
      trap_req <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= start;
      trap_req <= trap_fire & trap_hit;
      if (cmp_fire) cr_out <= cr_next;
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R2
  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) trap_req |-> done); // R10
  AST_TRAP_KEEPS_CR: assert property (@(posedge clk) disable iff (!rst_n) trap_fire |=> $stable(cr_out)); // R9
  AST_CMP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n) cmp_fire |=> !trap_req); // R9
  AST_REL_ONEHOT_S: assert property (@(posedge clk) disable iff (!rst_n) $countones({rel.slt, rel.sgt, rel.eq}) == 1); // R5
  AST_REL_ONEHOT_U: assert property (@(posedge clk) disable iff (!rst_n) $countones({rel.ult, rel.ugt, rel.eq}) == 1); // R5
  AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_fire |=> ((cr_out ^ $past(cr_out)) & $past(keep_mask)) == '0); // R7
endmodule

// File: tb/tb_cmp_trap_unit.sv
module tb_cmp_trap_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_sel = 1'b0;
  logic        signed_sel = 1'b0;
  logic        use_imm = 1'b0;
  logic [15:0] imm = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [2:0]  fld_sel = '0;
  logic [4:0]  trap_opts = '0;
  logic        sum_ovf = 1'b0;
  logic [31:0] cr_out;
  logic        trap_req;
  logic        done;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] model_cr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_trap_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
    .signed_sel(signed_sel), .use_imm(use_imm), .imm(imm),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .fld_sel(fld_sel),
    .trap_opts(trap_opts), .sum_ovf(sum_ovf),
    .cr_out(cr_out), .trap_req(trap_req), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] b_of(input bit ui, input bit sg, input logic [15:0] im, input logic [31:0] rb);
    if (!ui) return rb;
    if (sg) return 32'($signed(im));
    return {16'h0, im};
  endfunction

  function automatic logic [3:0] exp_nib(input logic [31:0] a, input logic [31:0] b, input bit sg, input bit so);
    bit lt, gt;
    lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    gt = sg ? ($signed(a) > $signed(b)) : (a > b);
    return {lt, gt, a == b, so};
  endfunction

  function automatic bit exp_trap(input logic [31:0] a, input logic [31:0] b, input logic [4:0] m);
    return (m[4] && $signed(a) < $signed(b)) || (m[3] && $signed(a) > $signed(b)) ||
           (m[2] && a == b) || (m[1] && a < b) || (m[0] && a > b);
  endfunction

  // Issue one operation; sample at the negedge after the registering edge.
  task automatic issue(input bit op, input bit sg, input bit ui, input logic [15:0] im,
                       input logic [31:0] a, input logic [31:0] rb, input logic [2:0] f,
                       input logic [4:0] m, input bit so, input string req);
    logic [31:0] b;
    int lo;
    @(negedge clk);
    op_sel = op; signed_sel = sg; use_imm = ui; imm = im; opnd_a = a; opnd_b = rb;
    fld_sel = f; trap_opts = m; sum_ovf = so; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    b = b_of(ui, sg, im, rb);
    if (!op) begin
      lo = 28 - 4 * int'(f);
      model_cr[lo +: 4] = exp_nib(a, b, sg, so);
    end
    chk(done === 1'b1, {req, " R2 done"}, 32'(done), 32'd1);
    chk(cr_out === model_cr, {req, " cr"}, cr_out, model_cr);
    chk(trap_req === (op ? exp_trap(a, b, m) : 1'b0), {req, " trap"}, 32'(trap_req),
        32'(op ? exp_trap(a, b, m) : 1'b0));
    @(negedge clk);
    chk(done === 1'b0 && trap_req === 1'b0, {req, " R2 R10 pulse ends"}, {30'b0, done, trap_req}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cr_out === 32'd0 && done === 1'b0 && trap_req === 1'b0, "R1 reset",
        {cr_out[29:0], done, trap_req}, 32'd0);
    rst_n = 1'b1;
    model_cr = '0;
  endtask

  task automatic t_signed_vs_unsigned();
    issue(1'b0, 1'b1, 1'b0, 16'h0, 32'hFFFF_FFFB, 32'd3, 3'd0, 5'h0, 1'b0, "R4 signed neg<pos");
    issue(1'b0, 1'b0, 1'b0, 16'h0, 32'hFFFF_FFFB, 32'd3, 3'd1, 5'h0, 1'b0, "R4 unsigned big>small");
    issue(1'b0, 1'b1, 1'b0, 16'h0, 32'h8000_0000, 32'h7FFF_FFFF, 3'd2, 5'h0, 1'b1, "R4 R5 extremes so");
    issue(1'b0, 1'b0, 1'b0, 16'h0, 32'h1234_5678, 32'h1234_5678, 3'd3, 5'h0, 1'b0, "R5 equal");
  endtask

  task automatic t_imm_ext();
    issue(1'b0, 1'b1, 1'b1, 16'hFFFF, 32'hFFFF_FFFF, 32'd0, 3'd4, 5'h0, 1'b0, "R3 sext -1 eq");
    issue(1'b0, 1'b0, 1'b1, 16'hFFFF, 32'hFFFF_FFFF, 32'd0, 3'd5, 5'h0, 1'b0, "R3 zext gt");
    issue(1'b0, 1'b0, 1'b1, 16'h8000, 32'h0000_8000, 32'hDEAD_BEEF, 3'd6, 5'h0, 1'b0, "R3 zext eq ignores opnd_b");
  endtask

  task automatic t_fields();
    for (int f = 0; f < 8; f++)
      issue(1'b0, 1'b0, 1'b0, 16'h0, 32'd1, 32'd2, 3'(f), 5'h0, f[0], "R6 R7 field walk");
  endtask

  task automatic t_trap();
    // a=-2 b=1: signed lt, unsigned gt
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'hFFFF_FFFE, 32'd1, 3'd0, 5'b10000, 1'b0, "R8 slt hit");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'hFFFF_FFFE, 32'd1, 3'd0, 5'b01000, 1'b0, "R8 sgt miss");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'hFFFF_FFFE, 32'd1, 3'd0, 5'b00010, 1'b0, "R8 ult miss");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'hFFFF_FFFE, 32'd1, 3'd0, 5'b00001, 1'b0, "R8 ugt hit");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'd1, 32'hFFFF_FFFE, 3'd0, 5'b01000, 1'b0, "R8 sgt hit");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'd1, 32'hFFFF_FFFE, 3'd0, 5'b00010, 1'b0, "R8 ult hit");
    issue(1'b1, 1'b1, 1'b1, 16'hFFFE, 32'hFFFF_FFFE, 32'd0, 3'd0, 5'b00100, 1'b0, "R8 eq imm hit");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'd7, 32'd7, 3'd0, 5'b11011, 1'b0, "R8 eq disabled");
    issue(1'b1, 1'b0, 1'b0, 16'h0, 32'd7, 32'd9, 3'd0, 5'b00000, 1'b0, "R8 none enabled");
  endtask

  task automatic t_exclusive();
    issue(1'b0, 1'b1, 1'b0, 16'h0, 32'd5, 32'd5, 3'd7, 5'b11111, 1'b1, "R9 cmp no trap");
    issue(1'b1, 1'b1, 1'b0, 16'h0, 32'd5, 32'd9, 3'd7, 5'b11111, 1'b0, "R9 trap keeps cr");
  endtask

  task automatic t_idle();
    repeat (3) begin
      @(negedge clk);
      chk(done === 1'b0 && trap_req === 1'b0, "R2 R10 idle", {30'b0, done, trap_req}, 32'd0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_signed_vs_unsigned();
    t_imm_ext();
    t_fields();
    t_trap();
    t_exclusive();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule